// File: doc/BRIEF.md
# ECC Write Path with Read-Modify-Write

This block sits between a host request port and a plain memory port. It protects every 64-bit memory word with an 8-bit single-error-correct, double-error-detect check byte. A write that enables all eight bytes is encoded and written at once. A write that enables only some bytes is turned into a sequence: the block reads the stored word and checks it, optionally corrects it, merges in the new bytes and writes the merged word back with freshly computed check bits.

Reads return the stored word together with one-cycle flags for single-bit and multi-bit errors. A single-bit error is repaired in the returned data only while the global correction enable is high. With the enable low the raw data passes through and the error is still flagged. One enable covers the whole memory, because a mix of protected and unprotected words is not allowed.

The host presents one request at a time. `reqReady` is high only while the block is idle. The memory port issues one-cycle commands and accepts read data whenever `memRValid` is asserted.

Top module: `eccRmwUnit`

## Requirements
- R1: After reset `reqReady` is 1, and `memReq`, `rspValid`, `rspSingleErr`, `rspMultiErr` and `wrAbort` are all 0.
- R2: A write with `reqByteEn` = 8'hFF issues one memory write and no memory read. The word written is the request data unchanged. The all-zero word is stored with check byte 8'h00.
- R3: A read of an error-free word returns the stored data with both error flags low. `rspValid` is high for exactly one cycle per read and never for a write.
- R4: Flipping any one stored bit, in the data or in the check byte, makes a read report `rspSingleErr` = 1 and `rspMultiErr` = 0.
- R5: With `corrEn` = 1, a single flipped data bit is repaired in `rspData`. With `corrEn` = 0, `rspData` equals the raw stored data.
- R6: Two flipped data bits make a read report `rspMultiErr` = 1 and `rspSingleErr` = 0, and `rspData` equals the raw stored data.
- R7: A write with some but not all byte enables set performs one read of the same address and then one write. Byte b of the written word (bits 8b+7:8b) comes from the request where `reqByteEn[b]` = 1 and from the stored word otherwise. A later read of that word is clean.
- R8: In a partial write whose read finds a single-bit error with `corrEn` = 1, the merged word is built from the corrected stored data.
- R9: In a partial write whose read finds a multi-bit error, no memory write is issued, `wrAbort` pulses for one cycle and the stored word is left unchanged.
- R10: `reqReady` is 0 from the cycle after a request is accepted until the operation completes. The error flags are never high while `rspValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| corrEn | input | 1 | Global enable for single-bit correction |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Block idle and able to accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqData | input | 64 | Write data |
| reqByteEn | input | 8 | Byte enables for writes |
| rspValid | output | 1 | Read data valid (one-cycle pulse) |
| rspData | output | 64 | Read data |
| rspSingleErr | output | 1 | Single-bit error seen on this read |
| rspMultiErr | output | 1 | Multi-bit error seen on this read |
| wrAbort | output | 1 | Partial write dropped because of an uncorrectable error |
| memReq | output | 1 | Memory command valid |
| memWrite | output | 1 | 1 = memory write, 0 = memory read |
| memAddr | output | ADDR_W | Memory word address |
| memWData | output | 64 | Memory write data |
| memWCheck | output | 8 | Memory write check byte |
| memRValid | input | 1 | Memory read data valid |
| memRData | input | 64 | Memory read data |
| memRCheck | input | 8 | Memory read check byte |

## Verification
The hardest cases are the error paths inside a partial write, because a fault in the stored word only shows up through the bytes that the merge keeps. The bench models the memory itself and flips bits directly in its stored arrays between operations. It then issues partial writes over corrupted words and inspects the merged word in the model. This exposes correction inside the merge and, for a double flip, the missing write-back together with the abort pulse. A following read of the same word confirms that the fresh check byte is clean.

// File: rtl/eccRmwPkg.sv
package eccRmwPkg;
  localparam int DATA_W = 64;
  localparam int BYTE_N = DATA_W / 8;
  localparam int HAM_W  = 7;
  localparam int CHK_W  = HAM_W + 1;

  typedef struct packed {
    logic loadReq;
    logic loadMerge;
    logic captureRsp;
  } dpStrobeT;

  // codeword position of data bit idx (powers of two hold Hamming bits)
  function automatic int unsigned dataPos(input int unsigned idx);
    int unsigned pos;
    int unsigned res;
    pos = 2;
    res = 0;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      pos = pos + 1;
      if ((pos & (pos - 1)) == 0) pos = pos + 1;
      if (i == idx) res = pos;
    end
    return res;
  endfunction

  // check byte: [HAM_W-1:0] Hamming bits, [HAM_W] overall even parity
  function automatic logic [CHK_W-1:0] eccEncode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    int unsigned pos;
    h = '0;
    pos = 2;
    for (int i = 0; i < DATA_W; i++) begin
      pos = pos + 1;
      if ((pos & (pos - 1)) == 0) pos = pos + 1;
      for (int k = 0; k < HAM_W; k++)
        if (pos[k]) h[k] = h[k] ^ d[i];
    end
    return {^{d, h}, h};
  endfunction
endpackage

// File: rtl/eccRmwDatapath.sv
module eccRmwDatapath
  import eccRmwPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              corrEn,
  input  dpStrobeT          strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [BYTE_N-1:0] reqByteEn,
  input  logic [DATA_W-1:0] memRData,
  input  logic [CHK_W-1:0]  memRCheck,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic [CHK_W-1:0]  memWCheck,
  output logic              errSingle,
  output logic              errMulti,
  output logic [DATA_W-1:0] rspData,
  output logic              rspSingleErr,
  output logic              rspMultiErr
);
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wordReg;
  logic [BYTE_N-1:0] beReg;
  logic [HAM_W-1:0]  syndrome;
  logic              parityErr;
  logic [CHK_W-1:0]  recomputed;
  logic [DATA_W-1:0] corrected;
  logic [DATA_W-1:0] fixedData;
  logic [DATA_W-1:0] mergedWord;

  // decode of the word coming back from memory
  always_comb begin
    recomputed = eccEncode(memRData);
    syndrome   = recomputed[HAM_W-1:0] ^ memRCheck[HAM_W-1:0];
    parityErr  = ^{memRData, memRCheck};
    errSingle  = parityErr;
    errMulti   = !parityErr && (syndrome != '0);
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_fix
    localparam int unsigned POS = dataPos(i);
    assign corrected[i] = memRData[i] ^ (errSingle && (syndrome == POS[HAM_W-1:0]));
  end

  assign fixedData = corrEn ? corrected : memRData;

  for (genvar b = 0; b < BYTE_N; b++) begin : g_merge
    assign mergedWord[8*b +: 8] = beReg[b] ? wordReg[8*b +: 8] : fixedData[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg      <= '0;
      wordReg      <= '0;
      beReg        <= '0;
      rspData      <= '0;
      rspSingleErr <= 1'b0;
      rspMultiErr  <= 1'b0;
    end else begin
      if (strobe.loadReq) begin
        addrReg <= reqAddr;
        wordReg <= reqData;
        beReg   <= reqByteEn;
      end else if (strobe.loadMerge) begin
        wordReg <= mergedWord;
      end
      if (strobe.captureRsp) rspData <= fixedData;
      rspSingleErr <= strobe.captureRsp && errSingle;
      rspMultiErr  <= strobe.captureRsp && errMulti;
    end
  end

  assign memAddr   = addrReg;
  assign memWData  = wordReg;
  assign memWCheck = eccEncode(wordReg);

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rspSingleErr && rspMultiErr)); // R4
  AST_MERGE_NO_LOAD_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadReq && strobe.loadMerge)); // R7
endmodule

// File: rtl/eccRmwControl.sv
module eccRmwControl
  import eccRmwPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [BYTE_N-1:0] reqByteEn,
  input  logic              memRValid,
  input  logic              errMulti,
  output logic              reqReady,
  output logic              memReq,
  output logic              memWrite,
  output logic              rspValid,
  output logic              wrAbort,
  output dpStrobeT          strobe
);
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RDREQ,
    ST_RDWAIT,
    ST_WR
  } stateT;

  stateT stateQ, stateD;
  logic  isWrQ;
  logic  accept;
  logic  fullWord;
  logic  readBack;

  assign accept   = reqValid && (stateQ == ST_IDLE);
  assign fullWord = &reqByteEn;
  assign readBack = (stateQ == ST_RDWAIT) && memRValid;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      ST_IDLE: if (accept) begin
        strobe.loadReq = 1'b1;
        stateD = (reqWrite && fullWord) ? ST_WR : ST_RDREQ;
      end
      ST_RDREQ: stateD = ST_RDWAIT;
      ST_RDWAIT: if (memRValid) begin
        if (!isWrQ) begin
          strobe.captureRsp = 1'b1;
          stateD = ST_IDLE;
        end else if (errMulti) begin
          stateD = ST_IDLE;
        end else begin
          strobe.loadMerge = 1'b1;
          stateD = ST_WR;
        end
      end
      ST_WR: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      isWrQ    <= 1'b0;
      rspValid <= 1'b0;
      wrAbort  <= 1'b0;
    end else begin
      stateQ   <= stateD;
      if (accept) isWrQ <= reqWrite;
      rspValid <= readBack && !isWrQ;
      wrAbort  <= readBack && isWrQ && errMulti;
    end
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign memReq   = (stateQ == ST_RDREQ) || (stateQ == ST_WR);
  assign memWrite = (stateQ == ST_WR);

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R3
  AST_FULL_SKIP_READ: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && fullWord) |=> (memReq && memWrite)); // R2
  AST_PARTIAL_READ_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && !fullWord) |=> (memReq && !memWrite)); // R7
  AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrAbort |-> !memWrite); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady); // R10
endmodule

// File: rtl/eccRmwUnit.sv
module eccRmwUnit
  import eccRmwPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              corrEn,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [BYTE_N-1:0] reqByteEn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspSingleErr,
  output logic              rspMultiErr,
  output logic              wrAbort,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic [CHK_W-1:0]  memWCheck,
  input  logic              memRValid,
  input  logic [DATA_W-1:0] memRData,
  input  logic [CHK_W-1:0]  memRCheck
);
  dpStrobeT strobe;
  logic     errSingle;
  logic     errMulti;

  eccRmwControl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqByteEn (reqByteEn),
    .memRValid (memRValid),
    .errMulti  (errMulti),
    .reqReady  (reqReady),
    .memReq    (memReq),
    .memWrite  (memWrite),
    .rspValid  (rspValid),
    .wrAbort   (wrAbort),
    .strobe    (strobe)
  );

  eccRmwDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .corrEn       (corrEn),
    .strobe       (strobe),
    .reqAddr      (reqAddr),
    .reqData      (reqData),
    .reqByteEn    (reqByteEn),
    .memRData     (memRData),
    .memRCheck    (memRCheck),
    .memAddr      (memAddr),
    .memWData     (memWData),
    .memWCheck    (memWCheck),
    .errSingle    (errSingle),
    .errMulti     (errMulti),
    .rspData      (rspData),
    .rspSingleErr (rspSingleErr),
    .rspMultiErr  (rspMultiErr)
  );

  AST_FLAGS_WITH_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (rspSingleErr || rspMultiErr) |-> rspValid); // R10
endmodule

// File: tb/eccRmwUnit_tb_top.sv
`timescale 1ns/1ps
module eccRmwUnit_tb_top;
  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        corrEn = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [63:0] reqData = '0;
  logic [7:0]  reqByteEn = '0;
  logic        rspValid;
  logic [63:0] rspData;
  logic        rspSingleErr;
  logic        rspMultiErr;
  logic        wrAbort;
  logic        memReq;
  logic        memWrite;
  logic [AW-1:0] memAddr;
  logic [63:0] memWData;
  logic [7:0]  memWCheck;
  logic        memRValid = 1'b0;
  logic [63:0] memRData = '0;
  logic [7:0]  memRCheck = '0;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  eccRmwUnit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .corrEn(corrEn),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .reqByteEn(reqByteEn),
    .rspValid(rspValid), .rspData(rspData), .rspSingleErr(rspSingleErr),
    .rspMultiErr(rspMultiErr), .wrAbort(wrAbort),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memWData(memWData), .memWCheck(memWCheck),
    .memRValid(memRValid), .memRData(memRData), .memRCheck(memRCheck)
  );

  // memory model, 16 words, one-cycle read latency
  logic [63:0] memD [16];
  logic [7:0]  memC [16];
  int rdCount = 0;
  int wrCount = 0;

  always @(posedge clk) begin
    memRValid <= 1'b0;
    if (memReq && memWrite) begin
      memD[memAddr[3:0]] <= memWData;
      memC[memAddr[3:0]] <= memWCheck;
      wrCount <= wrCount + 1;
    end else if (memReq) begin
      memRValid <= 1'b1;
      memRData  <= memD[memAddr[3:0]];
      memRCheck <= memC[memAddr[3:0]];
      rdCount <= rdCount + 1;
    end
  end

  // results of the last operation
  logic [63:0] gotData;
  logic        gotSingle, gotMulti;
  int          rspCount, abortCount;
  bit          sawBusy;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input bit w, input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be);
    rspCount = 0; abortCount = 0; sawBusy = 1'b0;
    gotSingle = 1'b0; gotMulti = 1'b0; gotData = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqData = d; reqByteEn = be;
    @(negedge clk);
    reqValid = 1'b0;
    sawBusy = !reqReady;
    for (int i = 0; i < 40; i++) begin
      if (rspValid) begin
        rspCount++;
        gotData = rspData; gotSingle = rspSingleErr; gotMulti = rspMultiErr;
      end
      if (wrAbort) abortCount++;
      if (reqReady) break;
      @(negedge clk);
    end
    // one more cycle to see any late pulse and settle the memory model
    @(negedge clk);
    if (rspValid) rspCount++;
    if (wrAbort) abortCount++;
  endtask

  function automatic logic [63:0] mergeBytes(input logic [63:0] oldW, input logic [63:0] newW, input logic [7:0] be);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = be[b] ? newW[8*b +: 8] : oldW[8*b +: 8];
    return r;
  endfunction

  task automatic testReset();
    chk(reqReady == 1'b1, "R1 reqReady", 64'(reqReady), 64'd1);
    chk(memReq == 1'b0 && rspValid == 1'b0, "R1 memReq/rspValid", 64'({memReq, rspValid}), 64'd0);
    chk({rspSingleErr, rspMultiErr, wrAbort} == 3'b000, "R1 flags", 64'({rspSingleErr, rspMultiErr, wrAbort}), 64'd0);
  endtask

  task automatic testFullWrite();
    int r0, w0;
    r0 = rdCount; w0 = wrCount;
    runOp(1'b1, 16'd1, 64'h0123_4567_89AB_CDEF, 8'hFF);
    chk(rdCount == r0 && wrCount == w0 + 1, "R2 one write no read", 64'((rdCount - r0) * 16 + (wrCount - w0)), 64'd1);
    chk(memD[1] == 64'h0123_4567_89AB_CDEF, "R2 stored data", memD[1], 64'h0123_4567_89AB_CDEF);
    chk(rspCount == 0, "R3 no rsp on write", 64'(rspCount), 64'd0);
    runOp(1'b1, 16'd2, 64'h0, 8'hFF);
    chk(memC[2] == 8'h00, "R2 zero word check byte", 64'(memC[2]), 64'h0);
  endtask

  task automatic testCleanRead();
    runOp(1'b0, 16'd1, 64'h0, 8'h00);
    chk(sawBusy, "R10 not ready while busy", 64'(sawBusy), 64'd1);
    chk(rspCount == 1, "R3 single rsp pulse", 64'(rspCount), 64'd1);
    chk(gotData == 64'h0123_4567_89AB_CDEF, "R3 read data", gotData, 64'h0123_4567_89AB_CDEF);
    chk(!gotSingle && !gotMulti, "R3 clean flags", 64'({gotSingle, gotMulti}), 64'd0);
  endtask

  task automatic testSingleErr();
    logic [63:0] good;
    good = 64'hDEAD_BEEF_CAFE_F00D;
    runOp(1'b1, 16'd3, good, 8'hFF);
    @(negedge clk); memD[3][17] = ~memD[3][17];
    corrEn = 1'b1;
    runOp(1'b0, 16'd3, 64'h0, 8'h00);
    chk(gotSingle && !gotMulti, "R4 data flip flags", 64'({gotSingle, gotMulti}), 64'b10);
    chk(gotData == good, "R5 corrected data", gotData, good);
    corrEn = 1'b0;
    runOp(1'b0, 16'd3, 64'h0, 8'h00);
    chk(gotSingle && !gotMulti, "R4 flags corr off", 64'({gotSingle, gotMulti}), 64'b10);
    chk(gotData == (good ^ (64'd1 << 17)), "R5 raw data corr off", gotData, good ^ (64'd1 << 17));
    corrEn = 1'b1;
    @(negedge clk); memD[3][17] = ~memD[3][17]; memC[3][3] = ~memC[3][3];
    runOp(1'b0, 16'd3, 64'h0, 8'h00);
    chk(gotSingle && !gotMulti, "R4 check-bit flip flags", 64'({gotSingle, gotMulti}), 64'b10);
    chk(gotData == good, "R4 check-bit flip data", gotData, good);
    @(negedge clk); memC[3][7] = ~memC[3][7]; memC[3][3] = ~memC[3][3];
    runOp(1'b0, 16'd3, 64'h0, 8'h00);
    chk(gotSingle && !gotMulti, "R4 parity-bit flip flags", 64'({gotSingle, gotMulti}), 64'b10);
    @(negedge clk); memC[3][7] = ~memC[3][7];
  endtask

  task automatic testDoubleErr();
    logic [63:0] good;
    good = 64'h5555_AAAA_3333_CCCC;
    runOp(1'b1, 16'd4, good, 8'hFF);
    @(negedge clk); memD[4][5] = ~memD[4][5]; memD[4][40] = ~memD[4][40];
    runOp(1'b0, 16'd4, 64'h0, 8'h00);
    chk(!gotSingle && gotMulti, "R6 double flags", 64'({gotSingle, gotMulti}), 64'b01);
    chk(gotData == (good ^ (64'd1 << 5) ^ (64'd1 << 40)), "R6 raw data", gotData,
        good ^ (64'd1 << 5) ^ (64'd1 << 40));
  endtask

  task automatic testPartialClean();
    logic [63:0] oldW, newW, expW;
    int r0, w0;
    oldW = 64'h1111_2222_3333_4444; newW = 64'hAAAA_BBBB_CCCC_DDDD;
    runOp(1'b1, 16'd5, oldW, 8'hFF);
    r0 = rdCount; w0 = wrCount;
    runOp(1'b1, 16'd5, newW, 8'h0F);
    expW = mergeBytes(oldW, newW, 8'h0F);
    chk(rdCount == r0 + 1 && wrCount == w0 + 1, "R7 one read one write", 64'((rdCount - r0) * 16 + (wrCount - w0)), 64'h11);
    chk(memD[5] == expW, "R7 merged word", memD[5], expW);
    runOp(1'b0, 16'd5, 64'h0, 8'h00);
    chk(gotData == expW && !gotSingle && !gotMulti, "R7 reread clean", gotData, expW);
  endtask

  task automatic testPartialSingle();
    logic [63:0] oldW, newW, expW;
    oldW = 64'h0F0F_0F0F_F0F0_F0F0; newW = 64'h9999_8888_7777_6666;
    corrEn = 1'b1;
    runOp(1'b1, 16'd6, oldW, 8'hFF);
    @(negedge clk); memD[6][50] = ~memD[6][50];
    runOp(1'b1, 16'd6, newW, 8'h81);
    expW = mergeBytes(oldW, newW, 8'h81);
    chk(memD[6] == expW, "R8 merged from corrected", memD[6], expW);
    runOp(1'b0, 16'd6, 64'h0, 8'h00);
    chk(gotData == expW && !gotSingle && !gotMulti, "R8 reread clean", gotData, expW);
  endtask

  task automatic testPartialDouble();
    logic [63:0] oldW, badW;
    int w0;
    oldW = 64'h7777_0000_FFFF_1234;
    runOp(1'b1, 16'd7, oldW, 8'hFF);
    @(negedge clk); memD[7][1] = ~memD[7][1]; memD[7][60] = ~memD[7][60];
    badW = memD[7];
    w0 = wrCount;
    runOp(1'b1, 16'd7, 64'hFFFF_FFFF_FFFF_FFFF, 8'h3C);
    chk(wrCount == w0, "R9 no write-back", 64'(wrCount - w0), 64'd0);
    chk(abortCount == 1, "R9 abort pulse", 64'(abortCount), 64'd1);
    chk(memD[7] == badW, "R9 memory unchanged", memD[7], badW);
    chk(rspCount == 0, "R10 no rsp on aborted write", 64'(rspCount), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin memD[i] = '0; memC[i] = '0; end
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFullWrite();
    testCleanRead();
    testSingleErr();
    testDoubleErr();
    testPartialClean();
    testPartialSingle();
    testPartialDouble();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule